// File: doc/BRIEF.md
# Configurable UART Frame Line Coder

This block turns parallel characters into asynchronous serial frames and back again. The line conventions can be changed. Each frame has one start bit, a data field of `DATA_W` bits (8 by default), an even parity bit that can be switched off, and one stop bit. Software can choose four line options: which data bit goes first, whether the data (and parity) travel in negative logic, whether each pad's whole waveform is inverted, and whether the transmit and receive roles of the two pads are exchanged. The exchange of pad roles suits a crossed cable.

An external baud generator supplies `baud_tick`. It pulses `TICKS_PER_BIT` times per bit period. The transmitter holds each line bit for that many ticks. The receiver finds a falling edge, re-checks the line half a bit later, and then samples each following bit in the middle of the bit. Characters enter through a valid/ready handshake. Received characters are held, together with their parity and framing flags, until the consumer accepts them.

All option inputs pass into an internal configuration register only while `enable` is low. While the block is enabled, changes on those inputs do nothing.

Top module: `uart_line_coder`

## Requirements
- R1: A transmitted frame has a low start bit, then the data bits, then the parity bit when `cfg_parity_en`=1, then a high stop bit. The line is high between frames. These levels are logical, before pad inversion.
- R2: With `cfg_msb_first`=0, data bit 0 follows the start bit. With `cfg_msb_first`=1, bit `DATA_W-1` follows the start bit. The receiver applies the same order.
- R3: With `cfg_data_inv`=1, each data bit and the parity bit travel inverted on both directions. The start bit and stop bit do not change.
- R4: With `cfg_tx_pol_inv`=1, the transmit pad carries the complement of every logical level, including idle.
- R5: With `cfg_rx_pol_inv`=1, the receiver complements the receive pad before it decodes anything, including the idle level.
- R6: With `cfg_swap`=0, pad 0 transmits (`pad0_oe`=1) and pad 1 is the receive input. With `cfg_swap`=1, the roles exchange. While `enable`=0, neither output enable is asserted.
- R7: The six `cfg_*` inputs are captured only while `enable`=0. Changes while enabled have no effect on either direction.
- R8: The parity bit is the XOR of the data bits (even parity). On receive, `rx_parity_err`=1 when the received parity does not match the recovered data. It is always 0 when parity is disabled.
- R9: A stop bit sampled low sets `rx_frame_err` with the delivered character.
- R10: A low pulse on the receive line that ends before the half-bit re-check does not produce a character.
- R11: `tx_ready` is high only while enabled and idle, and it drops after a character is accepted. `rx_valid` stays high until `rx_ready` is seen.
- R12: Every transmitted bit after the start bit lasts exactly `TICKS_PER_BIT` baud ticks. The line changes only after a tick or a character load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Block enable; options load while low |
| cfg_msb_first | input | 1 | Send and expect the top data bit first |
| cfg_data_inv | input | 1 | Negative logic for data and parity |
| cfg_tx_pol_inv | input | 1 | Invert the whole transmit pad waveform |
| cfg_rx_pol_inv | input | 1 | Invert the whole receive pad waveform |
| cfg_swap | input | 1 | Exchange the transmit and receive pads |
| cfg_parity_en | input | 1 | Add and check an even parity bit |
| baud_tick | input | 1 | Pulses `TICKS_PER_BIT` times per bit |
| tx_valid | input | 1 | Character to send is present |
| tx_ready | output | 1 | Transmitter accepts a character |
| tx_data | input | DATA_W | Character to send |
| rx_valid | output | 1 | Received character is held |
| rx_ready | input | 1 | Consumer takes the held character |
| rx_data | output | DATA_W | Received character |
| rx_parity_err | output | 1 | Parity mismatch on the held character |
| rx_frame_err | output | 1 | Low stop bit on the held character |
| pad0_i | input | 1 | Pad 0 input level |
| pad0_o | output | 1 | Pad 0 output level |
| pad0_oe | output | 1 | Pad 0 output enable |
| pad1_i | input | 1 | Pad 1 input level |
| pad1_o | output | 1 | Pad 1 output level |
| pad1_oe | output | 1 | Pad 1 output enable |

## Verification
The assertions assume the following about the inputs. `baud_tick` is a single-cycle pulse, and a full bit period spans at least two clocks. Options change only while `enable` is low. The receive line is asynchronous but stays put for whole bit periods. The bench builds its tick from a fixed divider. It changes options only through a disable/enable sequence, except in the single test that checks that writes made while enabled are ignored. Its received frames hold each level for a full bit period. The only exception is a deliberate short glitch. The pad that is not in use is held at its active level, so any misrouting produces garbage characters.

// File: rtl/uart_lc_pkg.sv
package uart_lc_pkg;

   // Line option set captured while the block is disabled
   typedef struct packed {
      logic msb_first;
      logic data_inv;
      logic tx_pol_inv;
      logic rx_pol_inv;
      logic swap;
      logic parity_en;
   } lc_cfg_t;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_START,
      ST_DATA,
      ST_PAR,
      ST_STOP
   } lc_state_t;

endpackage

// File: rtl/uart_lc_tx.sv
module uart_lc_tx
   import uart_lc_pkg::*;
#(
   parameter int DATA_W        = 8,
   parameter int TICKS_PER_BIT = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              enable,
   input  logic              tick,
   input  logic              msb_first,
   input  logic              data_inv,
   input  logic              parity_en,
   input  logic              tx_valid,
   input  logic [DATA_W-1:0] tx_data,
   output logic              tx_ready,
   output logic              line_raw
);
   localparam int CNT_W = (TICKS_PER_BIT > 2) ? $clog2(TICKS_PER_BIT) : 1;
   localparam int NB_W  = $clog2(DATA_W + 1);

   lc_state_t         st;
   logic [CNT_W-1:0]  cnt;
   logic [NB_W-1:0]   nbit;
   logic [DATA_W-1:0] sh;
   logic [DATA_W-1:0] rev;
   logic              par;
   logic              bit_end;

   // Bit order is fixed once at load: shift out LSB of the chosen image
   for (genvar i = 0; i < DATA_W; i++) begin : g_rev
      assign rev[i] = tx_data[DATA_W-1-i];
   end

   assign bit_end  = tick && (cnt == CNT_W'(TICKS_PER_BIT - 1));
   assign tx_ready = enable && (st == ST_IDLE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st       <= ST_IDLE;
         cnt      <= '0;
         nbit     <= '0;
         sh       <= '0;
         par      <= 1'b0;
         line_raw <= 1'b1;
      end else if (!enable) begin
         st       <= ST_IDLE;
         cnt      <= '0;
         line_raw <= 1'b1;
      end else if (st == ST_IDLE) begin
         line_raw <= 1'b1;
         if (tx_valid) begin
            sh       <= msb_first ? rev : tx_data;
            par      <= ^tx_data;
            st       <= ST_START;
            cnt      <= '0;
            line_raw <= 1'b0;
         end
      end else if (tick) begin
         if (!bit_end) begin
            cnt <= cnt + 1'b1;
         end else begin
            cnt <= '0;
            case (st)
               ST_START: begin
                  line_raw <= sh[0] ^ data_inv;
                  sh       <= sh >> 1;
                  nbit     <= NB_W'(1);
                  st       <= ST_DATA;
               end
               ST_DATA: begin
                  if (nbit == NB_W'(DATA_W)) begin
                     st       <= parity_en ? ST_PAR : ST_STOP;
                     line_raw <= parity_en ? (par ^ data_inv) : 1'b1;
                  end else begin
                     line_raw <= sh[0] ^ data_inv;
                     sh       <= sh >> 1;
                     nbit     <= nbit + 1'b1;
                  end
               end
               ST_PAR: begin
                  st       <= ST_STOP;
                  line_raw <= 1'b1;
               end
               default: begin
                  st       <= ST_IDLE;
                  line_raw <= 1'b1;
               end
            endcase
         end
      end
   end

   assert_start_after_accept_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_valid && tx_ready) |=> (line_raw == 1'b0));

   assert_ready_drops_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_valid && tx_ready) |=> !tx_ready);

   assert_line_on_tick_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (line_raw != $past(line_raw)) |-> ($past(tick) || $past(tx_valid && tx_ready) || !$past(enable)));

endmodule

// File: rtl/uart_lc_rx.sv
module uart_lc_rx
   import uart_lc_pkg::*;
#(
   parameter int DATA_W        = 8,
   parameter int TICKS_PER_BIT = 4,
   parameter int SYNC_STAGES   = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              enable,
   input  logic              tick,
   input  logic              msb_first,
   input  logic              data_inv,
   input  logic              rx_pol_inv,
   input  logic              parity_en,
   input  logic              rx_pin,
   input  logic              rx_ready,
   output logic              rx_valid,
   output logic [DATA_W-1:0] rx_data,
   output logic              rx_parity_err,
   output logic              rx_frame_err
);
   localparam int CNT_W = (TICKS_PER_BIT > 2) ? $clog2(TICKS_PER_BIT) : 1;
   localparam int NB_W  = $clog2(DATA_W + 1);
   localparam int HALF  = TICKS_PER_BIT / 2;

   lc_state_t              st;
   logic [SYNC_STAGES-1:0] sq;
   logic [CNT_W-1:0]       cnt;
   logic [NB_W-1:0]        nbit;
   logic [DATA_W-1:0]      sh;
   logic [DATA_W-1:0]      rev;
   logic                   pbit;
   logic                   line;

   for (genvar i = 0; i < DATA_W; i++) begin : g_rev
      assign rev[i] = sh[DATA_W-1-i];
   end

   // Logical line after synchronisation and pad polarity correction
   assign line = sq[SYNC_STAGES-1] ^ rx_pol_inv;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st            <= ST_IDLE;
         sq            <= '1;
         cnt           <= '0;
         nbit          <= '0;
         sh            <= '0;
         pbit          <= 1'b0;
         rx_valid      <= 1'b0;
         rx_data       <= '0;
         rx_parity_err <= 1'b0;
         rx_frame_err  <= 1'b0;
      end else begin
         sq <= {sq[SYNC_STAGES-2:0], rx_pin};
         if (rx_valid && rx_ready) rx_valid <= 1'b0;
         if (!enable) begin
            st  <= ST_IDLE;
            cnt <= '0;
         end else if (tick) begin
            case (st)
               ST_IDLE: begin
                  if (!line) begin
                     st  <= ST_START;
                     cnt <= '0;
                  end
               end
               ST_START: begin
                  // R10: re-check the start level half a bit after the edge
                  if (cnt == CNT_W'(HALF - 1)) begin
                     cnt  <= '0;
                     nbit <= '0;
                     st   <= line ? ST_IDLE : ST_DATA;
                  end else begin
                     cnt <= cnt + 1'b1;
                  end
               end
               default: begin
                  if (cnt != CNT_W'(TICKS_PER_BIT - 1)) begin
                     cnt <= cnt + 1'b1;
                  end else begin
                     cnt <= '0;
                     case (st)
                        ST_DATA: begin
                           sh   <= {line ^ data_inv, sh[DATA_W-1:1]};
                           nbit <= nbit + 1'b1;
                           if (nbit == NB_W'(DATA_W - 1))
                              st <= parity_en ? ST_PAR : ST_STOP;
                        end
                        ST_PAR: begin
                           pbit <= line ^ data_inv;
                           st   <= ST_STOP;
                        end
                        ST_STOP: begin
                           rx_valid      <= 1'b1;
                           rx_data       <= msb_first ? rev : sh;
                           rx_parity_err <= parity_en & (pbit ^ (^sh));
                           rx_frame_err  <= ~line;
                           st            <= ST_IDLE;
                        end
                        default: st <= ST_IDLE;
                     endcase
                  end
               end
            endcase
         end
      end
   end

   assert_hold_until_taken_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_valid && !rx_ready) |=> rx_valid);

   assert_no_perr_without_parity_R8: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(rx_valid) && !parity_en) |-> !rx_parity_err);

endmodule

// File: rtl/uart_lc_pinmux.sv
module uart_lc_pinmux (
   input  logic enable,
   input  logic swap,
   input  logic tx_pol_inv,
   input  logic tx_line_raw,
   input  logic pad0_i,
   input  logic pad1_i,
   output logic pad0_o,
   output logic pad0_oe,
   output logic pad1_o,
   output logic pad1_oe,
   output logic rx_pin
);
   logic tx_level;

   assign tx_level = tx_line_raw ^ tx_pol_inv;
   assign pad0_o   = tx_level;
   assign pad1_o   = tx_level;
   assign pad0_oe  = enable & ~swap;
   assign pad1_oe  = enable & swap;
   assign rx_pin   = swap ? pad0_i : pad1_i;

endmodule

// File: rtl/uart_line_coder.sv
module uart_line_coder
   import uart_lc_pkg::*;
#(
   parameter int DATA_W        = 8,
   parameter int TICKS_PER_BIT = 4,
   parameter int SYNC_STAGES   = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              enable,
   input  logic              cfg_msb_first,
   input  logic              cfg_data_inv,
   input  logic              cfg_tx_pol_inv,
   input  logic              cfg_rx_pol_inv,
   input  logic              cfg_swap,
   input  logic              cfg_parity_en,
   input  logic              baud_tick,
   input  logic              tx_valid,
   output logic              tx_ready,
   input  logic [DATA_W-1:0] tx_data,
   output logic              rx_valid,
   input  logic              rx_ready,
   output logic [DATA_W-1:0] rx_data,
   output logic              rx_parity_err,
   output logic              rx_frame_err,
   input  logic              pad0_i,
   output logic              pad0_o,
   output logic              pad0_oe,
   input  logic              pad1_i,
   output logic              pad1_o,
   output logic              pad1_oe
);
   if (DATA_W < 2) begin : g_bad_width
      $error("uart_line_coder: DATA_W must be at least 2");
   end
   if ((TICKS_PER_BIT < 2) || (TICKS_PER_BIT % 2 != 0)) begin : g_bad_ticks
      $error("uart_line_coder: TICKS_PER_BIT must be even and at least 2");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("uart_line_coder: SYNC_STAGES must be at least 2");
   end

   lc_cfg_t cfg_d, cfg_q;
   logic    tx_line_raw;
   logic    rx_pin;

   assign cfg_d = '{msb_first:  cfg_msb_first,
                    data_inv:   cfg_data_inv,
                    tx_pol_inv: cfg_tx_pol_inv,
                    rx_pol_inv: cfg_rx_pol_inv,
                    swap:       cfg_swap,
                    parity_en:  cfg_parity_en};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       cfg_q <= '0;
      else if (!enable) cfg_q <= cfg_d;
   end

   uart_lc_tx #(.DATA_W(DATA_W), .TICKS_PER_BIT(TICKS_PER_BIT)) u_tx (
      .clk       (clk),
      .rst_n     (rst_n),
      .enable    (enable),
      .tick      (baud_tick),
      .msb_first (cfg_q.msb_first),
      .data_inv  (cfg_q.data_inv),
      .parity_en (cfg_q.parity_en),
      .tx_valid  (tx_valid),
      .tx_data   (tx_data),
      .tx_ready  (tx_ready),
      .line_raw  (tx_line_raw)
   );

   uart_lc_rx #(.DATA_W(DATA_W), .TICKS_PER_BIT(TICKS_PER_BIT), .SYNC_STAGES(SYNC_STAGES)) u_rx (
      .clk           (clk),
      .rst_n         (rst_n),
      .enable        (enable),
      .tick          (baud_tick),
      .msb_first     (cfg_q.msb_first),
      .data_inv      (cfg_q.data_inv),
      .rx_pol_inv    (cfg_q.rx_pol_inv),
      .parity_en     (cfg_q.parity_en),
      .rx_pin        (rx_pin),
      .rx_ready      (rx_ready),
      .rx_valid      (rx_valid),
      .rx_data       (rx_data),
      .rx_parity_err (rx_parity_err),
      .rx_frame_err  (rx_frame_err)
   );

   uart_lc_pinmux u_pins (
      .enable      (enable),
      .swap        (cfg_q.swap),
      .tx_pol_inv  (cfg_q.tx_pol_inv),
      .tx_line_raw (tx_line_raw),
      .pad0_i      (pad0_i),
      .pad1_i      (pad1_i),
      .pad0_o      (pad0_o),
      .pad0_oe     (pad0_oe),
      .pad1_o      (pad1_o),
      .pad1_oe     (pad1_oe),
      .rx_pin      (rx_pin)
   );

   assert_cfg_frozen_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (enable && $past(enable)) |-> $stable(cfg_q));

   assert_pad_roles_R6: assert property (@(posedge clk) disable iff (!rst_n)
      enable |-> ((pad1_oe == cfg_q.swap) && (pad0_oe != pad1_oe)));

   assert_idle_level_R4: assert property (@(posedge clk) disable iff (!rst_n)
      tx_ready |-> ((cfg_q.swap ? pad1_o : pad0_o) == ~cfg_q.tx_pol_inv));

endmodule

// File: tb/test_uart_line_coder.sv
module test_uart_line_coder;
   localparam int CLK_PERIOD = 10;
   localparam int OSR        = 4;
   localparam int TDIV       = 2;
   localparam int BIT        = OSR * TDIV;
   localparam int HB         = BIT / 2;

   logic clk = 1'b0, rst_n = 1'b0, enable = 1'b0;
   logic c_msb = 0, c_dinv = 0, c_txinv = 0, c_rxinv = 0, c_swap = 0, c_par = 0;
   logic baud_tick = 1'b0, tx_valid = 1'b0, rx_ready = 1'b0;
   logic pad0_i = 1'b1, pad1_i = 1'b1;
   logic [7:0] tx_data = '0;
   wire        tx_ready, rx_valid, rx_parity_err, rx_frame_err;
   wire [7:0]  rx_data;
   wire        pad0_o, pad0_oe, pad1_o, pad1_oe;

   int n_run = 0, n_fail = 0;
   bit b_msb, b_dinv, b_txinv, b_rxinv, b_swap, b_par;

   uart_line_coder #(.DATA_W(8), .TICKS_PER_BIT(OSR), .SYNC_STAGES(2)) i_uart_line_coder (
      .clk(clk), .rst_n(rst_n), .enable(enable),
      .cfg_msb_first(c_msb), .cfg_data_inv(c_dinv), .cfg_tx_pol_inv(c_txinv),
      .cfg_rx_pol_inv(c_rxinv), .cfg_swap(c_swap), .cfg_parity_en(c_par),
      .baud_tick(baud_tick), .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
      .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data),
      .rx_parity_err(rx_parity_err), .rx_frame_err(rx_frame_err),
      .pad0_i(pad0_i), .pad0_o(pad0_o), .pad0_oe(pad0_oe),
      .pad1_i(pad1_i), .pad1_o(pad1_o), .pad1_oe(pad1_oe));

   always #(CLK_PERIOD/2) clk = ~clk;

   initial begin
      int tcnt = 0;
      forever begin
         @(negedge clk);
         baud_tick = (tcnt == TDIV - 1);
         tcnt = (tcnt == TDIV - 1) ? 0 : tcnt + 1;
      end
   end

   task automatic check(input bit ok, input string what, input logic [31:0] act, input logic [31:0] exp);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", what, act, exp);
      end
   endtask

   // Logical frame levels, index 0 first on the line
   function automatic logic [11:0] frame_bits(input logic [7:0] d, input bit bp, input bit bs, output int n);
      logic [11:0] f = '0;
      n = 1;
      for (int i = 0; i < 8; i++) begin
         f[n] = (b_msb ? d[7-i] : d[i]) ^ b_dinv;
         n++;
      end
      if (b_par) begin
         f[n] = (^d) ^ bp ^ b_dinv;
         n++;
      end
      f[n] = ~bs;
      n++;
      return f;
   endfunction

   task automatic set_rx_level(input logic lvl);
      if (b_swap) begin pad0_i = lvl; pad1_i = b_rxinv; end
      else        begin pad1_i = lvl; pad0_i = b_rxinv; end
   endtask

   task automatic apply_cfg(input bit m, input bit di, input bit ti, input bit ri, input bit sw, input bit pa);
      @(negedge clk);
      enable = 1'b0;
      b_msb = m; b_dinv = di; b_txinv = ti; b_rxinv = ri; b_swap = sw; b_par = pa;
      c_msb = m; c_dinv = di; c_txinv = ti; c_rxinv = ri; c_swap = sw; c_par = pa;
      set_rx_level(~ri);
      repeat (4) @(negedge clk);
      enable = 1'b1;
      repeat (3) @(negedge clk);
   endtask

   task automatic push_tx(input logic [7:0] d);
      @(negedge clk);
      tx_valid = 1'b1;
      tx_data  = d;
      while (!tx_ready) @(negedge clk);
      @(negedge clk);
      tx_valid = 1'b0;
   endtask

   task automatic cap_tx(input logic [7:0] d);
      int n;
      logic [11:0] exp, got;
      logic idle_lvl;
      exp = frame_bits(d, 1'b0, 1'b0, n);
      got = '0;
      idle_lvl = ~b_txinv;
      do @(negedge clk); while ((b_swap ? pad1_o : pad0_o) == idle_lvl);
      check((pad0_oe == ~b_swap) && (pad1_oe == b_swap), "R6 tx pad enables", {pad1_oe, pad0_oe}, {b_swap, ~b_swap});
      for (int i = 0; i < n; i++) begin
         repeat ((i == 0) ? HB : BIT) @(negedge clk);
         got[i] = b_swap ? pad1_o : pad0_o;
         if (i == 0) check(!tx_ready, "R11 tx_ready low mid-frame", tx_ready, 0);
      end
      for (int i = 0; i < n; i++) exp[i] = exp[i] ^ b_txinv;
      check(got == exp, "R1 R2 R3 R4 R8 R12 tx frame levels", got, exp);
   endtask

   task automatic drive_rx(input logic [7:0] d, input bit bp, input bit bs);
      int n;
      logic [11:0] f;
      f = frame_bits(d, bp, bs, n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         set_rx_level(f[i] ^ b_rxinv);
         repeat (BIT - 1) @(negedge clk);
      end
      @(negedge clk);
      set_rx_level(~b_rxinv);
      repeat (2 * BIT) @(negedge clk);
   endtask

   task automatic get_rx(input logic [7:0] d, input bit bp, input bit bs, input int hold);
      while (!rx_valid) @(negedge clk);
      if (hold > 0) begin
         repeat (hold) @(negedge clk);
         check(rx_valid, "R11 rx_valid held without rx_ready", rx_valid, 1);
      end
      check(rx_data == d, "R2 R3 R5 R6 rx data", rx_data, d);
      check(rx_parity_err == (b_par && bp), "R8 rx parity flag", rx_parity_err, b_par && bp);
      check(rx_frame_err == bs, "R9 rx framing flag", rx_frame_err, bs);
      rx_ready = 1'b1;
      @(negedge clk);
      rx_ready = 1'b0;
      check(!rx_valid, "R11 rx_valid cleared after rx_ready", rx_valid, 0);
   endtask

   task automatic run_frame(input logic [7:0] td, input logic [7:0] rd, input bit bp, input bit bs, input int hold);
      fork
         push_tx(td);
         cap_tx(td);
         drive_rx(rd, bp, bs);
         get_rx(rd, bp, bs, hold);
      join
   endtask

   task automatic finish_run;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      check(!tx_ready, "R11 tx_ready low while disabled", tx_ready, 0);
      check(!rx_valid, "R11 rx_valid low after reset", rx_valid, 0);
      check(!pad0_oe && !pad1_oe, "R6 no pad driven while disabled", {pad1_oe, pad0_oe}, 0);

      // Sweep all option combinations
      for (int c = 0; c < 64; c++) begin
         apply_cfg(c[0], c[1], c[2], c[3], c[4], c[5]);
         for (int k = 0; k < 6; k++) begin
            logic [7:0] td, rd;
            td = 8'((c * 37 + k * 91 + 5) & 255);
            rd = 8'(((c * 53) ^ (k * 29 + 113)) & 255);
            run_frame(td, rd, k == 4, k == 5, (k == 0) ? 12 : 0);
         end
      end

      // R10: short low glitch must not start a character
      apply_cfg(0, 0, 0, 1, 1, 1);
      @(negedge clk);
      set_rx_level(b_rxinv);
      repeat (2) @(negedge clk);
      set_rx_level(~b_rxinv);
      repeat (3 * BIT) @(negedge clk);
      check(!rx_valid, "R10 glitch rejected", rx_valid, 0);
      run_frame(8'h5A, 8'hC3, 1'b0, 1'b0, 0);

      // R7: option changes while enabled are ignored
      apply_cfg(0, 0, 0, 0, 0, 1);
      @(negedge clk);
      c_msb = 1; c_dinv = 1; c_txinv = 1; c_rxinv = 1; c_swap = 1; c_par = 0;
      run_frame(8'h3C, 8'hA5, 1'b0, 1'b0, 0);
      check(pad0_oe && !pad1_oe, "R7 pad roles unchanged while enabled", {pad1_oe, pad0_oe}, 1);
      apply_cfg(1, 1, 1, 1, 1, 0);
      run_frame(8'h3C, 8'hA5, 1'b0, 1'b0, 0);

      // Exhaustive data sweep on one configuration
      apply_cfg(1, 1, 0, 1, 0, 1);
      for (int d = 0; d < 256; d++) run_frame(8'(d), 8'(255 - d), 1'b0, 1'b0, 0);

      finish_run();
   end

endmodule